// File: doc/BRIEF.md
# TDM Daisy-Chain Output Serializer

This block drives one position of a serial audio frame that several devices share through a daisy chain. All devices run from one bit clock and one frame sync. Each device owns a 64-bit sub-frame made of two 32-bit channel slots, left first and right second. The frame is N such sub-frames long, where N is the number of chained devices. The frame rate is the output sample rate, so the bit clock runs at N × 64 × fs.

Each device sends its own stereo pair first, in sub-frame position zero. For the rest of the frame it forwards the serial stream it receives from the device upstream, delayed by one sub-frame. After the whole chain, the device at the downstream end therefore delivers every sub-frame in order.

The frame sync can come from outside (slave). It can also be made inside by dividing the bit clock by N × 64 (master), which matches a setup where the bit clock is the reference clock itself. Output bits are launched on the rising edge of `clk`, so a receiver samples them on the falling edge.

Top module: `tdm_chain_out`

## Requirements
- R1: After reset, and until the first frame sync is sampled, `sdo` is 0. In master mode `fsync_out` is also 0 during that time.
- R2: Take the rising edge that samples the frame sync as edge 0. After edge k, `sdo` carries frame bit k. Bits 0..31 hold the left sample, MSB first and left-justified. Slot bits at index SAMPLE_W and above are 0.
- R3: Frame bits 32..63 hold the right sample in the same way: MSB first, left-justified and zero-padded.
- R4: Both samples are captured at edge 0. Changes to `left_in` or `right_in` later in the frame do not alter the bits sent in that frame.
- R5: Frame bits 64..N×64-1 repeat `sdi`: the value of `sdi` sampled at one edge leaves on `sdo` 63 edges later. As a result, upstream frame bit k appears at position k+64.
- R6: In master mode `fsync_out` is high for exactly one clock every N×64 clocks. The first pulse follows the N×64-th edge after reset. The block starts its own frame at the edge that samples that pulse, and `fsync_in` is ignored. In slave mode `fsync_out` follows `fsync_in`.
- R7: If no new frame sync arrives after frame bit N×64-1, `sdo` stays 0 until the next frame sync is sampled.
- R8: With N = 1 there is no forwarding region, so `sdi` has no effect on `sdo`.
- R9: A frame sync sampled at any position restarts the frame at bit 0, with a newly captured sample pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fsync_in | input | 1 | External frame sync, one clock wide (slave mode) |
| left_in | input | SAMPLE_W | Left sample, captured at frame start |
| right_in | input | SAMPLE_W | Right sample, captured at frame start |
| sdi | input | 1 | Serial data from the upstream device |
| sdo | output | 1 | Serial data toward the downstream end |
| fsync_out | output | 1 | Generated (master) or forwarded (slave) frame sync |

## Verification
A frame sync can land on the same edge as a forwarded bit or a still-running own sub-frame. The block must then drop the forwarding or shifting work and load a fresh sample pair in that same cycle. The bench provokes this in two ways on a two-device chain: it issues a sync at position 90, in the middle of the forwarding region, and it sends syncs back to back exactly at the frame boundary. A behavioural model tracks position and sdi history and predicts every bit. Any cycle in which the restart and the forwarding logic fight over `sdo` shows up as a mismatch labelled with the restart requirement. The bench also changes the sample inputs on cycles unrelated to the frame, so that a capture mistimed by one edge is caught.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;

    localparam int SLOT_W = 32;
    localparam int SUB_W  = 2 * SLOT_W;

    typedef enum logic [1:0] {
        REG_IDLE = 2'd0,
        REG_OWN  = 2'd1,
        REG_PASS = 2'd2
    } region_e;

    typedef struct packed {
        logic [SLOT_W-1:0] left;
        logic [SLOT_W-1:0] right;
    } subframe_t;

    function automatic int frame_bits(input int n_dev);
        return n_dev * SUB_W;
    endfunction

    // Move a right-aligned sample to the top of its slot; low bits become 0.
    function automatic logic [SLOT_W-1:0] justify(input logic [SLOT_W-1:0] raw,
                                                  input int width);
        return raw << (SLOT_W - width);
    endfunction

endpackage

// File: rtl/tdm_fsync_gen.sv
module tdm_fsync_gen
    import tdm_chain_pkg::*;
#(
    parameter int FRAME = 256
) (
    input  logic clk,
    input  logic rst,
    output logic pulse
);
    localparam int DIV_W = (FRAME > 1) ? $clog2(FRAME) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(FRAME - 1);

    logic [DIV_W-1:0] cnt_q;
    logic             pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= (cnt_q == LAST);
            cnt_q   <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign pulse = pulse_q;
endmodule

// File: rtl/tdm_frame_pos.sv
module tdm_frame_pos
    import tdm_chain_pkg::*;
#(
    parameter int FRAME = 256
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sync,
    output region_e nxt_region,
    output logic    nxt_start
);
    localparam int POS_W = $clog2(FRAME + 1);
    localparam logic [POS_W-1:0] LAST    = POS_W'(FRAME - 1);
    localparam logic [POS_W-1:0] OWN_END = POS_W'(SUB_W);

    logic [POS_W-1:0] pos_q, pos_d;
    logic             active_q, active_d;

    always_comb begin
        nxt_start = sync;
        if (sync) begin
            pos_d    = '0;
            active_d = 1'b1;
        end else if (active_q && pos_q != LAST) begin
            pos_d    = pos_q + 1'b1;
            active_d = 1'b1;
        end else begin
            pos_d    = '0;
            active_d = 1'b0;
        end

        if (!active_d)
            nxt_region = REG_IDLE;
        else if (pos_d < OWN_END)
            nxt_region = REG_OWN;
        else
            nxt_region = REG_PASS;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q    <= '0;
            active_q <= 1'b0;
        end else begin
            pos_q    <= pos_d;
            active_q <= active_d;
        end
    end
endmodule

// File: rtl/tdm_subframe_shift.sv
module tdm_subframe_shift
    import tdm_chain_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  logic      shift,
    input  subframe_t data,
    output logic      head
);
    logic [SUB_W-1:0] sr_q;

    assign head = load ? data[SUB_W-1] : sr_q[SUB_W-1];

    always_ff @(posedge clk) begin
        if (rst)
            sr_q <= '0;
        else if (load)
            sr_q <= data << 1;
        else if (shift)
            sr_q <= sr_q << 1;
    end
endmodule

// File: rtl/tdm_delay_line.sv
module tdm_delay_line #(
    parameter int DEPTH = 63
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic tap
);
    logic [DEPTH-1:0] stage_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= {stage_q[DEPTH-2:0], din};
            end
        end
    endgenerate

    assign tap = stage_q[DEPTH-1];
endmodule

// File: rtl/tdm_chain_out.sv
module tdm_chain_out
    import tdm_chain_pkg::*;
#(
    parameter int N_DEV    = 4,
    parameter int SAMPLE_W = 24,
    parameter bit MASTER   = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fsync_in,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    input  logic                sdi,
    output logic                sdo,
    output logic                fsync_out
);
    localparam int FRAME = frame_bits(N_DEV);

    logic      fs_int;
    logic      pass_bit;
    logic      own_head;
    logic      nxt_start;
    region_e   nxt_region;
    subframe_t pair_d;
    logic      sdo_q;

    // Frame sync source
    generate
        if (MASTER) begin : g_master
            logic gen_pulse;
            logic unused_fsync_in;
            assign unused_fsync_in = fsync_in;
            tdm_fsync_gen #(.FRAME(FRAME)) i_fsync_gen (
                .clk  (clk),
                .rst  (rst),
                .pulse(gen_pulse)
            );
            assign fs_int    = gen_pulse;
            assign fsync_out = gen_pulse;
        end else begin : g_slave
            assign fs_int    = fsync_in;
            assign fsync_out = fsync_in;
        end
    endgenerate

    tdm_frame_pos #(.FRAME(FRAME)) i_frame_pos (
        .clk       (clk),
        .rst       (rst),
        .sync      (fs_int),
        .nxt_region(nxt_region),
        .nxt_start (nxt_start)
    );

    assign pair_d.left  = justify(SLOT_W'(left_in),  SAMPLE_W);
    assign pair_d.right = justify(SLOT_W'(right_in), SAMPLE_W);

    tdm_subframe_shift i_own_shift (
        .clk  (clk),
        .rst  (rst),
        .load (nxt_start),
        .shift((nxt_region == REG_OWN) && !nxt_start),
        .data (pair_d),
        .head (own_head)
    );

    // Upstream forwarding exists only when the chain has more than one device
    generate
        if (N_DEV > 1) begin : g_forward
            tdm_delay_line #(.DEPTH(SUB_W - 1)) i_delay (
                .clk(clk),
                .rst(rst),
                .din(sdi),
                .tap(pass_bit)
            );
        end else begin : g_no_forward
            logic unused_sdi;
            assign unused_sdi = sdi;
            assign pass_bit   = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo_q <= 1'b0;
        end else begin
            unique case (nxt_region)
                REG_OWN:  sdo_q <= own_head;
                REG_PASS: sdo_q <= pass_bit;
                default:  sdo_q <= 1'b0;
            endcase
        end
    end

    assign sdo = sdo_q;
endmodule

// File: rtl/tdm_chain_out_chk.sv
module tdm_chain_out_chk
    import tdm_chain_pkg::*;
#(
    parameter int N_DEV    = 4,
    parameter int SAMPLE_W = 24,
    parameter bit MASTER   = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic sync,
    input logic sdo,
    input logic fsync_out
);
    localparam int FRAME = frame_bits(N_DEV);

    logic        seen_q;
    logic [31:0] since_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= 1'b0;
            since_q <= '0;
        end else if (sync) begin
            seen_q  <= 1'b1;
            since_q <= '0;
        end else if (seen_q && since_q < 32'(FRAME)) begin
            since_q <= since_q + 1;
        end
    end

    // R1
    quiet_before_sync_chk: assert property (@(posedge clk) disable iff (rst)
        !seen_q |-> !sdo);

    // R7
    idle_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && since_q >= 32'(FRAME)) |-> !sdo);

    // R2 (zero padding of the left and right slots, R3)
    slot_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (seen_q && since_q < 32'(SUB_W) && (since_q % 32'(SLOT_W)) >= 32'(SAMPLE_W))
        |-> !sdo);

    generate
        if (MASTER) begin : g_master_chk
            logic        have_prev_q;
            logic [31:0] gap_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    have_prev_q <= 1'b0;
                    gap_q       <= '0;
                end else if (fsync_out) begin
                    have_prev_q <= 1'b1;
                    gap_q       <= 32'd1;
                end else begin
                    gap_q <= gap_q + 1;
                end
            end

            // R6
            sync_one_wide_chk: assert property (@(posedge clk) disable iff (rst)
                fsync_out |=> !fsync_out);

            // R6
            sync_period_chk: assert property (@(posedge clk) disable iff (rst)
                (fsync_out && have_prev_q) |-> gap_q == 32'(FRAME));
        end
    endgenerate
endmodule

bind tdm_chain_out tdm_chain_out_chk #(
    .N_DEV   (N_DEV),
    .SAMPLE_W(SAMPLE_W),
    .MASTER  (MASTER)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .sync     (fs_int),
    .sdo      (sdo),
    .fsync_out(fsync_out)
);

// File: tb/test_tdm_chain_out.sv
`timescale 1ns/1ps

module tdm_ref_model #(
    parameter int N      = 4,
    parameter int W      = 24,
    parameter bit MASTER = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fs_in,
    input  logic [W-1:0] left,
    input  logic [W-1:0] right,
    input  logic         sdi,
    output logic         exp_sdo,
    output logic         exp_fs,
    output int           pos,
    output bit           early,
    output bit           changed
);
    localparam int FRAME = N * 64;

    bit       hist[$];
    int       cnt;
    logic     fs_reg;
    logic [W-1:0] lat_l, lat_r;

    function automatic logic own_bit(input int k);
        logic [W-1:0] s;
        int j;
        s = (k < 32) ? lat_l : lat_r;
        j = k % 32;
        return (j < W) ? s[W-1-j] : 1'b0;
    endfunction

    assign exp_fs = MASTER ? fs_reg : fs_in;

    initial begin
        pos = -1; cnt = 0; fs_reg = 1'b0; exp_sdo = 1'b0;
        early = 0; changed = 0; lat_l = '0; lat_r = '0;
    end

    always @(posedge clk) begin
        logic fs_now;
        if (rst) begin
            pos = -1; cnt = 0; fs_reg = 1'b0; exp_sdo = 1'b0;
            early = 0; changed = 0; hist.delete();
        end else begin
            fs_now = MASTER ? fs_reg : fs_in;
            if (MASTER) begin
                fs_reg = (cnt == FRAME - 1);
                cnt    = (cnt == FRAME - 1) ? 0 : cnt + 1;
            end
            hist.push_front(sdi);
            if (hist.size() > 64) void'(hist.pop_back());
            if (fs_now) begin
                early = (pos >= 0 && pos < FRAME - 1);
                pos = 0; lat_l = left; lat_r = right; changed = 0;
            end else if (pos >= 0) begin
                pos++;
                if (pos == FRAME) pos = -1;
            end
            if (left != lat_l || right != lat_r) changed = 1;
            if (pos < 0)        exp_sdo = 1'b0;
            else if (pos < 64)  exp_sdo = own_bit(pos);
            else                exp_sdo = (hist.size() >= 64) ? hist[63] : 1'b0;
        end
    end
endmodule

module test_tdm_chain_out;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int total = 0;
    int bad   = 0;
    bit running = 0;
    int unsigned seed = 32'h1234_5678;

    // Config A: N=4, master, 24-bit
    logic [23:0] la = '0, ra = '0;
    logic sdi_a = 1'b0, sdo_a, fso_a;
    // Config B: N=2, slave, 16-bit, two chained devices
    logic [15:0] lbu = '0, rbu = '0, lbd = '0, rbd = '0;
    logic fs_b = 1'b0, sdo_bu, sdo_bd, fso_bu, fso_bd;
    // Config C: N=1, slave, 20-bit
    logic [19:0] lc = '0, rc = '0;
    logic fs_c = 1'b0, sdi_c = 1'b0, sdo_c, fso_c;

    tdm_chain_out #(.N_DEV(4), .SAMPLE_W(24), .MASTER(1'b1)) i_tdm_chain_out (
        .clk(clk), .rst(rst), .fsync_in(1'b0), .left_in(la), .right_in(ra),
        .sdi(sdi_a), .sdo(sdo_a), .fsync_out(fso_a));
    tdm_chain_out #(.N_DEV(2), .SAMPLE_W(16), .MASTER(1'b0)) i_tdm_chain_out_up (
        .clk(clk), .rst(rst), .fsync_in(fs_b), .left_in(lbu), .right_in(rbu),
        .sdi(1'b0), .sdo(sdo_bu), .fsync_out(fso_bu));
    tdm_chain_out #(.N_DEV(2), .SAMPLE_W(16), .MASTER(1'b0)) i_tdm_chain_out_dn (
        .clk(clk), .rst(rst), .fsync_in(fs_b), .left_in(lbd), .right_in(rbd),
        .sdi(sdo_bu), .sdo(sdo_bd), .fsync_out(fso_bd));
    tdm_chain_out #(.N_DEV(1), .SAMPLE_W(20), .MASTER(1'b0)) i_tdm_chain_out_n1 (
        .clk(clk), .rst(rst), .fsync_in(fs_c), .left_in(lc), .right_in(rc),
        .sdi(sdi_c), .sdo(sdo_c), .fsync_out(fso_c));

    logic e_a, ef_a, e_bu, ef_bu, e_bd, ef_bd, e_c, ef_c;
    int   p_a, p_bu, p_bd, p_c;
    bit   y_a, y_bu, y_bd, y_c, c_a, c_bu, c_bd, c_c;

    tdm_ref_model #(.N(4), .W(24), .MASTER(1'b1)) ref_a (
        .clk(clk), .rst(rst), .fs_in(1'b0), .left(la), .right(ra), .sdi(sdi_a),
        .exp_sdo(e_a), .exp_fs(ef_a), .pos(p_a), .early(y_a), .changed(c_a));
    tdm_ref_model #(.N(2), .W(16), .MASTER(1'b0)) ref_bu (
        .clk(clk), .rst(rst), .fs_in(fs_b), .left(lbu), .right(rbu), .sdi(1'b0),
        .exp_sdo(e_bu), .exp_fs(ef_bu), .pos(p_bu), .early(y_bu), .changed(c_bu));
    tdm_ref_model #(.N(2), .W(16), .MASTER(1'b0)) ref_bd (
        .clk(clk), .rst(rst), .fs_in(fs_b), .left(lbd), .right(rbd), .sdi(sdo_bu),
        .exp_sdo(e_bd), .exp_fs(ef_bd), .pos(p_bd), .early(y_bd), .changed(c_bd));
    tdm_ref_model #(.N(1), .W(20), .MASTER(1'b0)) ref_c (
        .clk(clk), .rst(rst), .fs_in(fs_c), .left(lc), .right(rc), .sdi(sdi_c),
        .exp_sdo(e_c), .exp_fs(ef_c), .pos(p_c), .early(y_c), .changed(c_c));

    function automatic int unsigned next_rand();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    function automatic string tag_of(input int p, input bit y, input bit c, input bit n1);
        if (p < 0)            return n1 ? "R8" : "R7";
        if (y && p < 64)      return "R9";
        if (c && p < 64)      return "R4";
        if (p < 32)           return "R2";
        if (p < 64)           return "R3";
        return "R5";
    endfunction

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s at %0t: actual=%b expected=%b", tag, what, $time, act, exp);
        end
    endtask

    // Compare against the reference model every clock, away from the edge
    always @(posedge clk) begin
        #1;
        if (running && !rst) begin
            check(sdo_a,  e_a,  tag_of(p_a,  y_a,  c_a,  1'b0), "sdo N4 master");
            check(fso_a,  ef_a, "R6", "fsync_out N4 master");
            check(sdo_bu, e_bu, tag_of(p_bu, y_bu, c_bu, 1'b0), "sdo N2 upstream");
            check(sdo_bd, e_bd, tag_of(p_bd, y_bd, c_bd, 1'b0), "sdo N2 downstream");
            check(fso_bd, ef_bd, "R6", "fsync_out N2 slave");
            check(sdo_c,  e_c,  tag_of(p_c,  y_c,  c_c,  1'b1), "sdo N1");
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stimulus
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        // R1: quiet after reset
        check(sdo_a,  1'b0, "R1", "sdo A after reset");
        check(fso_a,  1'b0, "R1", "fsync_out A after reset");
        check(sdo_bd, 1'b0, "R1", "sdo B after reset");
        check(sdo_c,  1'b0, "R1", "sdo C after reset");
        running = 1;
        for (int cyc = 0; cyc < 1500; cyc++) begin
            @(negedge clk);
            sdi_a = next_rand() % 2;
            sdi_c = next_rand() % 2;
            if (cyc % 37 == 0) begin
                la  = 24'(next_rand());  ra  = 24'(next_rand());
                lbu = 16'(next_rand());  rbu = 16'(next_rand());
                lbd = 16'(next_rand());  rbd = 16'(next_rand());
                lc  = 20'(next_rand());  rc  = 20'(next_rand());
            end
            // R9: early sync at 356; R7: idle gap until 700
            fs_b = (cyc == 10 || cyc == 138 || cyc == 266 || cyc == 356 ||
                    cyc == 700 || cyc == 828 || cyc == 956);
            fs_c = (cyc < 900) && (cyc % 64 == 5);
        end
        @(negedge clk);
        running = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule